// File: doc/BRIEF.md
# Pulse Accumulator with Flag Logic

This block counts activity on one external input pin in a 16-bit counter. In event mode each active edge on the pin adds one to the count. In gated mode the count advances once per 64 clocks for as long as the pin is held at its active level. The control register picks between rising and falling edges, or between an active-high and an active-low gate.

Two sticky flags report activity. The overflow flag is set when the count wraps. The input flag is set by each counted edge in event mode, and by the end of a gate pulse in gated mode. Each flag has its own interrupt enable. Software clears a flag by writing a one to its bit. An optional fast-clear mode also clears both flags whenever software reads or writes the counter.

Software reaches the block through a word-wide register port with separate read and write strobes. The port has a control word at address 0, the flag word at address 1 and the counter at address 2. Address 3 reads as zero.

Top module: `pulse_accum`

## Requirements
- R1: After synchronous reset the control word, the counter, the flags and both interrupt outputs are zero.
- R2: Control bit 0 is the global enable, bit 1 selects gated mode (0 = event mode) and bit 2 inverts the sense. In event mode with bit 2 clear, each rising pin edge adds one to the count and falling edges are ignored. With bit 2 set, only falling edges count.
- R3: In gated mode the count advances by one every 64 clock cycles while the synchronized pin is at its active level. The active level is high when bit 2 is clear and low when it is set. The first advance comes 64 cycles after the enable is written.
- R4: When the count wraps from 0xFFFF to 0x0000, the overflow flag (flag word bit 1) is set.
- R5: The input flag (flag word bit 0) is set by each counted edge in event mode. In gated mode it is set by the trailing edge of the gate and not by the leading edge.
- R6: Writing the flag word clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R7: The overflow interrupt equals the overflow flag ANDed with control bit 3. The input interrupt equals the input flag ANDed with control bit 4. Each interrupt output is registered one cycle behind its flag.
- R8: While control bit 5 is set, any read or write of the counter address clears both flags.
- R9: Flag word bits 15..2 read as zero. Address 3 reads as zero.
- R10: While the global enable is clear, pin activity changes neither the counter nor the flags.
- R11: A counter write takes priority over an increment in the same cycle. A flag set takes priority over a clear in the same cycle.
- R12: The pin passes through a two-flop synchronizer. A pin change made before clock edge k updates the counter and the flags at edge k+2, and the interrupt output at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pa_pin | input | 1 | Asynchronous event or gate input |
| reg_addr | input | 2 | Register address (0 ctrl, 1 flags, 2 counter) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_in | output | 1 | Input-activity interrupt request |

## Verification
A pin change made before edge k reaches the counter and the flags at edge k+2 and the interrupt outputs at edge k+3. Read data appears on the edge that samples the strobe. The bench drives and samples on falling clock edges. It probes the interrupt output exactly three and four falling edges after a pin change to bracket the R12 latency. For all other checks it waits at least four cycles after a pulse before reading. The priority cases place a write on the edge at which the synchronized edge lands, two edges after the pin change. The gated check writes the enable and then reads the count well inside the fourth 64-cycle window, so the expected tick total is exact.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;
  localparam int CTRL_BITS = 6;

  typedef struct packed {
    logic fclr;    // bit 5
    logic in_ie;   // bit 4
    logic ovf_ie;  // bit 3
    logic inv;     // bit 2
    logic gated;   // bit 1
    logic en;      // bit 0
  } ctrl_t;
endpackage

// File: rtl/pacc_insync.sv
module pacc_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !run)    div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  assign tick = run && (div_q == LAST);
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         roll
);
  localparam logic [W-1:0] MAXV = '1;

  logic bump;
  assign bump = en && inc && !wr;
  assign roll = bump && (cnt == MAXV);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wr)   cnt <= wdata;
    else if (bump) cnt <= cnt + 1'b1;
  end

  AST_WR_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    wr |=> cnt == $past(wdata)); // R11
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr) |=> $stable(cnt)); // R10
  AST_ROLL_ZERO: assert property (@(posedge clk) disable iff (rst)
    roll |=> cnt == '0); // R4
endmodule

// File: rtl/pacc_flags.sv
module pacc_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_ovf,
  input  logic       set_in,
  input  logic [1:0] clr,
  input  logic       ovf_ie,
  input  logic       in_ie,
  output logic [1:0] flags,
  output logic       irq_ovf,
  output logic       irq_in
);
  logic [1:0] set_v;
  assign set_v = {set_ovf, set_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      irq_ovf <= 1'b0;
      irq_in  <= 1'b0;
    end else begin
      flags   <= (flags & ~clr) | set_v;
      irq_ovf <= flags[1] & ovf_ie;
      irq_in  <= flags[0] & in_ie;
    end
  end

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    set_ovf |=> flags[1]); // R11
  AST_W1C_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!set_in && !clr[0]) |=> flags[0] == $past(flags[0])); // R6
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    irq_in |-> $past(in_ie && flags[0])); // R7
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum #(
  parameter int W      = 16,
  parameter int DIV    = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pa_pin,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         irq_ovf,
  output logic         irq_in
);
  import pacc_pkg::*;

  ctrl_t      ctrl;
  logic       lvl, rise, fall, tick;
  logic       act_edge, trail_edge, gate_on, inc, set_in, roll;
  logic       cnt_hit, cnt_wr;
  logic [1:0] clr, flags;
  logic [W-1:0] cnt;
  logic       unused_bits;

  assign unused_bits = ^reg_wdata[W-1:CTRL_BITS];

  always_ff @(posedge clk) begin
    if (rst)                                ctrl <= '0;
    else if (reg_wr && reg_addr == ADDR_CTRL) ctrl <= ctrl_t'(reg_wdata[CTRL_BITS-1:0]);
  end

  pacc_insync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(pa_pin), .lvl(lvl), .rise(rise), .fall(fall));

  pacc_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .run(ctrl.en && ctrl.gated), .tick(tick));

  assign act_edge   = ctrl.inv ? fall : rise;
  assign trail_edge = ctrl.inv ? rise : fall;
  assign gate_on    = lvl ^ ctrl.inv;
  assign inc        = ctrl.gated ? (tick && gate_on) : act_edge;
  assign set_in     = ctrl.en && (ctrl.gated ? trail_edge : act_edge);

  assign cnt_hit = (reg_wr || reg_rd) && reg_addr == ADDR_CNT;
  assign cnt_wr  = reg_wr && reg_addr == ADDR_CNT;

  pacc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .en(ctrl.en), .inc(inc), .wr(cnt_wr),
    .wdata(reg_wdata), .cnt(cnt), .roll(roll));

  always_comb begin
    clr = 2'b00;
    if (reg_wr && reg_addr == ADDR_FLAG) clr = reg_wdata[1:0];
    if (ctrl.fclr && cnt_hit)            clr = 2'b11;
  end

  pacc_flags u_flg (
    .clk(clk), .rst(rst), .set_ovf(roll), .set_in(set_in), .clr(clr),
    .ovf_ie(ctrl.ovf_ie), .in_ie(ctrl.in_ie),
    .flags(flags), .irq_ovf(irq_ovf), .irq_in(irq_in));

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        ADDR_CTRL: reg_rdata <= {{(W-CTRL_BITS){1'b0}}, ctrl};
        ADDR_FLAG: reg_rdata <= {{(W-2){1'b0}}, flags};
        ADDR_CNT:  reg_rdata <= cnt;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_FLAG) |=> reg_rdata[W-1:2] == '0); // R9
  AST_FAST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctrl.fclr && cnt_hit && !roll && !set_in) |=> flags == 2'b00); // R8
endmodule

// File: tb/pulse_accum_test.sv
module pulse_accum_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pa_pin = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_ovf, irq_in;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_cnt;
  logic [1:0]  exp_flg;
  logic [15:0] rd_v;

  always #2 clk = ~clk;

  pulse_accum uut (.clk(clk), .rst(rst), .pa_pin(pa_pin), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ovf(irq_ovf), .irq_in(irq_in));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [15:0] next_cnt(input logic [15:0] c);
    return c + 16'd1;
  endfunction

  function automatic logic [1:0] after_bump(input logic [15:0] c, input logic [1:0] f);
    return f | {c == 16'hFFFF, 1'b1};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  // one active edge then back to idle; idle = inv
  task automatic pulse(input logic inv);
    @(negedge clk); pa_pin = ~inv;
    repeat (4) @(negedge clk);
    pa_pin = inv;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] seed_v;
    seed_v = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, rd_v); check("R1 ctrl", rd_v, 0);
    rd(2'd2, rd_v); check("R1 count", rd_v, 0);
    rd(2'd1, rd_v); check("R1 flags", rd_v, 0);
    check("R1 irq", {irq_ovf, irq_in}, 0);

    // R10 disabled: edges ignored
    pulse(1'b0);
    rd(2'd2, rd_v); check("R10 count held", rd_v, 0);
    rd(2'd1, rd_v); check("R10 no flag", rd_v, 0);

    // R12 / R7 latency: event, rising, input irq enabled
    wr(2'd0, 16'h0011);
    @(negedge clk); pa_pin = 1'b1;          // edge k follows
    repeat (3) @(negedge clk); check("R12 irq not yet", irq_in, 0);
    @(negedge clk);            check("R12 irq at k+3", irq_in, 1);
    pa_pin = 1'b0; repeat (5) @(negedge clk);
    rd(2'd2, rd_v); check("R2 one rising edge", rd_v, 1);
    check("R7 ovf irq off", irq_ovf, 0);
    // R6 write 0 keeps, write 1 clears
    wr(2'd1, 16'h0000); rd(2'd1, rd_v); check("R6 write0 keeps", rd_v, 1);
    wr(2'd1, 16'h0001); rd(2'd1, rd_v); check("R6 write1 clears", rd_v, 0);
    check("R7 irq follows flag", irq_in, 0);

    // R4 rollover with ovf irq
    wr(2'd0, 16'h0009);
    wr(2'd2, 16'hFFFF);
    pulse(1'b0);
    rd(2'd2, rd_v); check("R4 wrap count", rd_v, 0);
    rd(2'd1, rd_v); check("R4 ovf flag", rd_v, 3);
    check("R7 ovf irq on", irq_ovf, 1);
    check("R7 in irq off", irq_in, 0);
    // R9 reserved bits / empty address
    wr(2'd1, 16'hFFFF); rd(2'd1, rd_v); check("R9 reserved zero", rd_v, 0);
    rd(2'd3, rd_v); check("R9 addr3 zero", rd_v, 0);

    // R11 counter write on increment edge
    wr(2'd0, 16'h0001);
    @(negedge clk); pa_pin = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_addr = 2'd2; reg_wdata = 16'h1234; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    pa_pin = 1'b0; repeat (4) @(negedge clk);
    rd(2'd2, rd_v); check("R11 write beats inc", rd_v, 16'h1234);
    // R11 flag set beats clear on the same edge
    wr(2'd1, 16'h0003);
    @(negedge clk); pa_pin = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_addr = 2'd1; reg_wdata = 16'h0001; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    pa_pin = 1'b0; repeat (4) @(negedge clk);
    rd(2'd1, rd_v); check("R11 set beats clear", rd_v, 1);

    // R8 fast clear on counter read and write
    wr(2'd0, 16'h0021);
    rd(2'd2, rd_v); check("R8 count unaffected", rd_v, 16'h1235);
    rd(2'd1, rd_v); check("R8 cleared by read", rd_v, 0);
    pulse(1'b0);
    wr(2'd2, 16'h0005);
    rd(2'd1, rd_v); check("R8 cleared by write", rd_v, 0);
    wr(2'd0, 16'h0001); pulse(1'b0);
    rd(2'd2, rd_v);
    rd(2'd1, rd_v); check("R8 off keeps flags", rd_v, 1);

    // R2 falling sense
    wr(2'd0, 16'h0000); pa_pin = 1'b1; repeat (5) @(negedge clk);
    wr(2'd2, 16'h0000); wr(2'd1, 16'h0003);
    wr(2'd0, 16'h0005);
    pulse(1'b1); pulse(1'b1);
    rd(2'd2, rd_v); check("R2 falling edges", rd_v, 2);

    // R3 / R5 gated mode, active-high gate
    wr(2'd0, 16'h0000); pa_pin = 1'b0; repeat (5) @(negedge clk);
    wr(2'd2, 16'h0000); wr(2'd1, 16'h0003);
    wr(2'd0, 16'h0003);
    pa_pin = 1'b1;
    repeat (5) @(negedge clk);
    rd(2'd1, rd_v); check("R5 leading edge no flag", rd_v, 0);
    repeat (64*3 + 20) @(negedge clk);
    rd(2'd2, rd_v); check("R3 gated ticks", rd_v, 3);
    pa_pin = 1'b0; repeat (5) @(negedge clk);
    rd(2'd1, rd_v); check("R5 trailing edge flag", rd_v, 1);
    repeat (130) @(negedge clk);
    rd(2'd2, rd_v); check("R3 gate closed holds", rd_v, 3);

    // random event-mode traffic, rising then falling sense
    for (int seg = 0; seg < 2; seg++) begin
      logic inv, oie, iie;
      inv = seg[0]; oie = 1'($urandom % 2); iie = 1'($urandom % 2);
      wr(2'd0, 16'h0000); pa_pin = inv; repeat (5) @(negedge clk);
      exp_cnt = 16'hFFF8 + 16'($urandom % 4);
      wr(2'd2, exp_cnt); wr(2'd1, 16'h0003); exp_flg = 2'b00;
      wr(2'd0, {11'd0, iie, oie, inv, 1'b0, 1'b1});
      for (int i = 0; i < 40; i++) begin
        case ($urandom % 4)
          0: begin
            pulse(inv);
            exp_flg = after_bump(exp_cnt, exp_flg);
            exp_cnt = next_cnt(exp_cnt);
          end
          1: begin
            logic [1:0] m;
            m = 2'($urandom % 4);
            wr(2'd1, {14'd0, m});
            exp_flg = exp_flg & ~m;
          end
          2: begin
            rd(2'd2, rd_v); check("R2 random count", rd_v, exp_cnt);
          end
          default: begin
            rd(2'd1, rd_v); check("R4 R5 random flags", rd_v, exp_flg);
            check("R7 random irq", {irq_ovf, irq_in}, {exp_flg[1] & oie, exp_flg[0] & iie});
          end
        endcase
      end
    end
    finish_run();
  end
endmodule